// File: doc/BRIEF.md
# Receive Character FIFO with Fill Threshold and Idle Timeout

This block buffers received serial characters between a receiver shifter and a host. Every entry holds one data byte plus three error flags: parity error, framing error and line-break. The entry at the head is always shown on the read outputs along with its flags, and a host read pops it. A control write sets the enable bit and the fill threshold, and can also issue a one-shot clear.

Two signals tell the host when to read. The first is a threshold flag that stays high while the fill level is at or above the programmed threshold. The second is an idle flag that rises when data waits unread and no character has been pushed or popped for four character times. The character-time tick comes from outside the block. An aggregate flag shows whether any stored entry carries an error. A sticky overrun flag records a push that arrived while the FIFO was full.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset the FIFO is empty: `count_o`=0. All flags are 0, `fifo_en_o`=0 and `trig_lvl_o`=0.
- R2: While `fifo_en_o`=0, pushes are dropped, pops are ignored, and `trig_o` and `timeout_o` are held at 0. Stored entries are kept and become visible again once the FIFO is re-enabled.
- R3: A control write loads `ctrl_wdata_i[0]` into the enable bit and `ctrl_wdata_i[7:6]` into the threshold code. If `ctrl_wdata_i[1]`=1, the FIFO is emptied and the overrun flag is cleared. This clear acts only once, and later pushes are stored normally.
- R4: The threshold code selects a fill threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 entries.
- R5: `trig_o` is 1 while the FIFO is enabled and `count_o` is at or above the threshold. It falls in the cycle after the read that takes the count below the threshold.
- R6: Entries leave in arrival order. The head entry's data appears on `rd_data_o` and its flags on `rd_perr_o`, `rd_ferr_o` and `rd_brk_o`. All four read outputs are 0 when the FIFO is empty.
- R7: `timeout_o` rises once four `tick_i` cycles have been seen while data is held, with no accepted push or pop in between. An accepted push or pop restarts the count and clears `timeout_o`. `timeout_o` is never 1 while the FIFO is empty.
- R8: `err_any_o` is 1 while at least one stored entry has any of its three error flags set. It returns to 0 once every such entry has been popped.
- R9: A push into a full FIFO (16 entries) is dropped, sets `overrun_o`, and leaves both the contents and the order unchanged. A push and a pop in the same cycle while full are both accepted.
- R10: A pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Receiver delivers a character |
| push_data_i | input | 8 | Received byte |
| push_perr_i | input | 1 | Parity error of the byte |
| push_ferr_i | input | 1 | Framing error of the byte |
| push_brk_i | input | 1 | Line-break seen with the byte |
| pop_i | input | 1 | Host read of the head entry |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bit 0 enable, bit 1 clear, bits 7:6 threshold code |
| tick_i | input | 1 | One-cycle pulse per character time |
| rd_data_o | output | 8 | Head data |
| rd_perr_o | output | 1 | Head parity error |
| rd_ferr_o | output | 1 | Head framing error |
| rd_brk_o | output | 1 | Head break flag |
| count_o | output | 5 | Number of stored entries |
| fifo_en_o | output | 1 | Enable bit |
| trig_lvl_o | output | 2 | Threshold code |
| trig_o | output | 1 | Fill threshold reached |
| timeout_o | output | 1 | Idle timeout with data waiting |
| err_any_o | output | 1 | Some stored entry has an error |
| overrun_o | output | 1 | Sticky flag: a push was dropped because the FIFO was full |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that a clear write never coincides with a push or pop the bench expects to be accepted. They also assume the default depth of 16 and a timeout of four ticks. The stimulus drives every input on the falling edge and returns it to 0 right after the next rising edge, so each push, pop, tick or control write lasts exactly one cycle. Clears are issued only in cycles with no other traffic. Both the full-FIFO cases and the empty-FIFO cases are reached on purpose, so that the overrun, idle and aggregate-error properties each get exercised.

// File: rtl/rx_char_fifo_pkg.sv
package rx_char_fifo_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  output logic          en_o,
  output logic [1:0]    lvl_o,
  output logic          clr_o,
  output logic [CW-1:0] thr_o
);
  logic unused_bits;
  assign unused_bits = ^wdata_i[5:2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      lvl_o <= 2'd0;
    end else if (we_i) begin
      en_o  <= wdata_i[0];
      lvl_o <= wdata_i[7:6];
    end
  end

  // bit 1 is never stored: one-shot clear
  assign clr_o = we_i & wdata_i[1];

  always_comb begin
    unique case (lvl_o)
      2'd0:    thr_o = CW'(1);
      2'd1:    thr_o = CW'(DEPTH / 4);
      2'd2:    thr_o = CW'(DEPTH / 2);
      default: thr_o = CW'(DEPTH - 2);
    endcase
  end

  p_lvl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(lvl_o) && $stable(en_o));
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
  import rx_char_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          push_i,
  input  rx_entry_t     wr_entry_i,
  input  logic          pop_i,
  output rx_entry_t     head_o,
  output logic [CW-1:0] count_o,
  output logic          err_any_o,
  output logic          ovf_o,
  output logic          act_o
);
  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q, err_cnt_q;
  logic          ovf_q;
  logic          full, empty, push_ok, pop_ok, wr_err, hd_err;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = en_i & pop_i & ~empty & ~clr_i;
  assign push_ok = en_i & push_i & (~full | pop_ok) & ~clr_i;
  assign wr_err  = wr_entry_i.perr | wr_entry_i.ferr | wr_entry_i.brk;
  assign hd_err  = mem_q[rptr_q].perr | mem_q[rptr_q].ferr | mem_q[rptr_q].brk;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wr_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
      ovf_q     <= 1'b0;
    end else if (clr_i) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      err_cnt_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      cnt_q     <= cnt_q + CW'(push_ok) - CW'(pop_ok);
      err_cnt_q <= err_cnt_q + CW'(push_ok & wr_err) - CW'(pop_ok & hd_err);
      if (en_i & push_i & full & ~pop_ok) ovf_q <= 1'b1;
    end
  end

  assign head_o    = empty ? '0 : mem_q[rptr_q];
  assign count_o   = cnt_q;
  assign err_any_o = (err_cnt_q != '0);
  assign ovf_o     = ovf_q;
  assign act_o     = push_ok | pop_ok;

  p_count_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH) && err_cnt_q <= cnt_q);
  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && en_i && push_i && !pop_i && !clr_i) |=> (cnt_q == CW'(DEPTH)) && ovf_q);
  p_empty_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && pop_i && !push_i) |=> (cnt_q == '0));
  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !ovf_q && !err_any_o);
  p_err_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !err_any_o);
  p_disabled_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_fifo_idle.sv
module rx_fifo_idle #(
  parameter int TO_CHARS = 4,
  localparam int TW = $clog2(TO_CHARS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic act_i,
  input  logic nonempty_i,
  input  logic tick_i,
  output logic timeout_o
);
  logic [TW-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            idle_q <= '0;
    else if (clr_i || act_i || !nonempty_i) idle_q <= '0;
    else if (tick_i && idle_q != TW'(TO_CHARS)) idle_q <= idle_q + 1'b1;
  end

  assign timeout_o = en_i & nonempty_i & (idle_q == TW'(TO_CHARS));

  p_idle_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_q <= TW'(TO_CHARS));
  p_act_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !timeout_o);
  p_to_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> nonempty_i);
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rx_char_fifo_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              push_perr_i,
  input  logic              push_ferr_i,
  input  logic              push_brk_i,
  input  logic              pop_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_brk_o,
  output logic [CW-1:0]     count_o,
  output logic              fifo_en_o,
  output logic [1:0]        trig_lvl_o,
  output logic              trig_o,
  output logic              timeout_o,
  output logic              err_any_o,
  output logic              overrun_o
);
  logic          en, clr, act;
  logic [CW-1:0] thr;
  rx_entry_t     wr_entry, head;

  assign wr_entry = '{brk: push_brk_i, ferr: push_ferr_i, perr: push_perr_i, data: push_data_i};

  rx_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we_i), .wdata_i(ctrl_wdata_i),
    .en_o(en), .lvl_o(trig_lvl_o), .clr_o(clr), .thr_o(thr)
  );

  rx_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en), .push_i, .wr_entry_i(wr_entry),
    .pop_i, .head_o(head), .count_o, .err_any_o, .ovf_o(overrun_o), .act_o(act)
  );

  rx_fifo_idle #(.TO_CHARS(TO_CHARS)) u_idle (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(en), .act_i(act),
    .nonempty_i(count_o != '0), .tick_i, .timeout_o
  );

  assign fifo_en_o = en;
  assign rd_data_o = head.data;
  assign rd_perr_o = head.perr;
  assign rd_ferr_o = head.ferr;
  assign rd_brk_o  = head.brk;
  assign trig_o    = en & (count_o >= thr);

  p_trig_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_o |-> !trig_o && !timeout_o);
  p_trig_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> count_o != '0);
  p_empty_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> (rd_data_o == '0) && !rd_perr_o && !rd_ferr_o && !rd_brk_o);
endmodule

// File: tb/sim_rx_char_fifo.sv
module sim_rx_char_fifo;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       push = 0, perr = 0, ferr = 0, brk = 0, pop = 0, we = 0, tick = 0;
  logic [7:0] pdata = 0, wdata = 0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, fifo_en, trig, timeout, err_any, overrun;
  logic [4:0] count;
  logic [1:0] lvl;
  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_char_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata),
    .push_perr_i(perr), .push_ferr_i(ferr), .push_brk_i(brk), .pop_i(pop),
    .ctrl_we_i(we), .ctrl_wdata_i(wdata), .tick_i(tick),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk),
    .count_o(count), .fifo_en_o(fifo_en), .trig_lvl_o(lvl), .trig_o(trig),
    .timeout_o(timeout), .err_any_o(err_any), .overrun_o(overrun)
  );

  typedef struct packed {
    logic       push;
    logic [7:0] d;
    logic [2:0] e;     // {brk, ferr, perr}
    logic       pop;
    logic [4:0] cnt;
    logic [7:0] head;
    logic       erra;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA1, 3'b000, 1'b0, 5'd1, 8'hA1, 1'b0},
    '{1'b1, 8'hB2, 3'b001, 1'b0, 5'd2, 8'hA1, 1'b1},
    '{1'b1, 8'hC3, 3'b000, 1'b0, 5'd3, 8'hA1, 1'b1},
    '{1'b1, 8'hD4, 3'b000, 1'b1, 5'd3, 8'hB2, 1'b1},
    '{1'b0, 8'h00, 3'b000, 1'b1, 5'd2, 8'hC3, 1'b0},
    '{1'b1, 8'hE5, 3'b100, 1'b0, 5'd3, 8'hC3, 1'b1},
    '{1'b0, 8'h00, 3'b000, 1'b1, 5'd2, 8'hD4, 1'b1},
    '{1'b0, 8'h00, 3'b000, 1'b1, 5'd1, 8'hE5, 1'b1},
    '{1'b0, 8'h00, 3'b000, 1'b1, 5'd0, 8'h00, 1'b0},
    '{1'b0, 8'h00, 3'b000, 1'b1, 5'd0, 8'h00, 1'b0}   // R10 pop on empty
  };

  localparam int THR [4] = '{1, 4, 8, 14};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; outputs sampled 2 ns after the capturing edge
  task automatic step(input logic pu, input logic [7:0] d, input logic [2:0] e,
                      input logic po, input logic tk);
    @(negedge clk);
    push = pu; pdata = d; {brk, ferr, perr} = e; pop = po; tick = tk;
    @(posedge clk);
    #2;
    push = 0; pdata = 0; {brk, ferr, perr} = 3'b0; pop = 0; tick = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    we = 1; wdata = v;
    @(posedge clk);
    #2;
    we = 0; wdata = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {trig, timeout, err_any, overrun}, 0);
    chk("R1 ctrl", {fifo_en, lvl}, 0);
    // R2 push while disabled is dropped
    step(1, 8'h11, 3'b0, 0, 0);
    chk("R2 push while disabled", count, 0);

    // table walk: order, head flags, aggregate error (R6, R8, R10)
    wr_ctrl(8'h43);
    chk("R3 enable and level", {fifo_en, lvl}, {1'b1, 2'd1});
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].push, VEC[i].d, VEC[i].e, VEC[i].pop, 0);
      chk($sformatf("R6 count row %0d", i), count, VEC[i].cnt);
      chk($sformatf("R6 head row %0d", i), rd_data, VEC[i].head);
      chk($sformatf("R8 err_any row %0d", i), err_any, VEC[i].erra);
    end

    // R6 head flags
    step(1, 8'h5A, 3'b010, 0, 0);
    chk("R6 head flags", {rd_brk, rd_ferr, rd_perr}, 3'b010);
    step(0, 0, 0, 1, 0);
    chk("R6 empty head flags", {rd_brk, rd_ferr, rd_perr, rd_data}, 0);

    // R4, R5 thresholds
    for (int c = 0; c < 4; c++) begin
      wr_ctrl({c[1:0], 6'b000011});
      chk("R4 level code", lvl, c);
      for (int k = 0; k < THR[c] - 1; k++) step(1, 8'(k), 3'b0, 0, 0);
      chk($sformatf("R4 below threshold %0d", THR[c]), trig, 0);
      step(1, 8'hFF, 3'b0, 0, 0);
      chk($sformatf("R4 at threshold %0d", THR[c]), trig, 1);
      step(0, 0, 0, 1, 0);
      chk($sformatf("R5 drop after read %0d", THR[c]), trig, 0);
    end

    // R9 full, simultaneous push/pop, overrun
    wr_ctrl(8'h03);
    for (int k = 0; k < 16; k++) step(1, 8'(k), 3'b0, 0, 0);
    chk("R9 full count", count, 16);
    step(1, 8'h77, 3'b0, 1, 0);
    chk("R9 push+pop when full count", count, 16);
    chk("R9 push+pop when full head", rd_data, 8'h01);
    chk("R9 no overrun yet", overrun, 0);
    step(1, 8'hEE, 3'b001, 0, 0);
    chk("R9 overrun set", overrun, 1);
    chk("R9 count unchanged", count, 16);
    chk("R8 dropped error not counted", err_any, 0);
    for (int k = 1; k < 16; k++) begin
      chk($sformatf("R9 order %0d", k), rd_data, 8'(k));
      step(0, 0, 0, 1, 0);
    end
    chk("R9 last entry", rd_data, 8'h77);
    step(1, 8'h33, 3'b0, 0, 0);

    // R3 one-shot clear
    wr_ctrl(8'h03);
    chk("R3 clear count", count, 0);
    chk("R3 clear overrun", overrun, 0);
    chk("R3 enable kept", fifo_en, 1);
    step(1, 8'h44, 3'b0, 0, 0);
    chk("R3 clear self-ends", count, 1);

    // R7 timeout
    step(1, 8'h45, 3'b0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 1);
    chk("R7 three ticks", timeout, 0);
    step(0, 0, 0, 0, 1);
    chk("R7 four ticks", timeout, 1);
    step(0, 0, 0, 1, 0);
    chk("R7 read clears", timeout, 0);
    repeat (3) step(0, 0, 0, 0, 1);
    step(1, 8'h46, 3'b0, 0, 0);
    repeat (3) step(0, 0, 0, 0, 1);
    chk("R7 push restarts", timeout, 0);
    step(0, 0, 0, 0, 1);
    chk("R7 after restart", timeout, 1);
    wr_ctrl(8'h03);
    repeat (5) step(0, 0, 0, 0, 1);
    chk("R7 never when empty", timeout, 0);

    // R2 disable with data held
    step(1, 8'h50, 3'b0, 0, 0);
    step(1, 8'h51, 3'b0, 0, 0);
    wr_ctrl(8'h00);
    chk("R2 disabled trig", trig, 0);
    step(0, 0, 0, 1, 0);
    chk("R2 pop ignored", count, 2);
    step(1, 8'h52, 3'b0, 0, 0);
    chk("R2 push dropped", count, 2);
    repeat (5) step(0, 0, 0, 0, 1);
    chk("R2 no timeout", timeout, 0);
    wr_ctrl(8'h01);
    chk("R2 re-enabled trig", trig, 1);
    chk("R2 contents kept", rd_data, 8'h50);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule